// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block carries out the table-read instruction of a small 8-bit processor core whose program memory is 16 bits wide. It owns a 16-bit table pointer and a 16-bit table latch. When the core presents an instruction word with a start strobe, the unit decodes it. It writes one byte of the latch to an 8-bit register-file address. It then refills the whole latch from the program memory word at the pointer, and may step the pointer by one.

The clock of the block is the phase clock: one clock period is one phase, and four phases form one instruction cycle. The register write happens in the last phase of the first cycle and uses the latch contents left by the previous table read. The memory fetch happens in the second cycle, with the active-low output-enable asserted in its last phase. When the destination is the program counter low byte, the unit stays busy for a third cycle so the core can flush its fetch. Status flags are never touched. The pointer can also be written one byte at a time by other parts of the core while the unit is idle.

Top module: `tblrd_unit`

## Requirements
- R1: An instruction is accepted only when `start` is high, the unit is idle, and `instr[15:10]` equals 6'b101010. Any other opcode is ignored: `busy` stays low and there is no register write and no memory read.
- R2: In an accepted word, bit 9 selects the byte (1 = latch bits [15:8], 0 = latch bits [7:0]) and bits [7:0] are the destination address. The selected byte is written with `rf_we` high for exactly one phase, the 4th phase after acceptance (phase index 3), with `rf_addr` equal to the destination.
- R3: The written byte comes from the latch as it was before the instruction. At the end of phase index 7 the latch is loaded with `pm_data`, read from `pm_addr` equal to the pointer value at the start of the instruction.
- R4: When bit 8 is 1 the pointer increases by one at the end of phase index 7, wrapping from 0xFFFF to 0x0000. When bit 8 is 0 the pointer is unchanged.
- R5: `busy` is high for 8 phases after acceptance, or for 12 phases when the destination equals the program counter low-byte address (0x02 by default).
- R6: A `start` that arrives while `busy` is high is ignored. It does not lengthen the execution, add a write, or start a second fetch.
- R7: After reset the pointer and the latch are zero, `busy` and `rf_we` are low, and `pm_oe_n` is high.
- R8: With `ptr_ld_en` high and the unit idle, `ptr_ld_byte` replaces pointer byte lane `ptr_ld_lane` (lane 0 = bits [7:0], lane 1 = bits [15:8]). The load is ignored while `busy` is high.
- R9: `pm_oe_n` is low only in phase index 7 of an accepted instruction and is high in every other phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one period per phase |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction present strobe |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Instruction in progress |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 8 | Register-file write address |
| rf_data | output | 8 | Register-file write data |
| pm_addr | output | 16 | Program memory address (the table pointer) |
| pm_oe_n | output | 1 | Program memory output enable, active low |
| pm_data | input | 16 | Program memory read data |
| ptr_ld_en | input | 1 | Pointer byte load enable |
| ptr_ld_lane | input | 1 | Pointer byte lane to load |
| ptr_ld_byte | input | 8 | Pointer byte value |

## Verification
The hardest case to reach is a start, or a pointer byte load, that arrives in the middle of an execution. A port-level bench normally waits for the unit to go idle before it acts. The stimulus therefore raises `start` with a second valid word in phase 2 of a running instruction. It also drives a pointer load during another busy window. It then checks that the phase count, the single write and the final pointer are unchanged. The pointer wrap is reached by loading 0xFFFF through the byte lanes before a post-incrementing read.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
   localparam logic [5:0] TBLRD_OPCODE = 6'b101010;
   localparam int OPC_LSB  = 10;
   localparam int HI_BIT   = 9;
   localparam int INC_BIT  = 8;

   function automatic logic opcode_hit(input logic [15:0] w);
      return w[15:OPC_LSB] == TBLRD_OPCODE;
   endfunction
endpackage

// File: rtl/tblrd_decode.sv
module tblrd_decode #(
   parameter int          WORD_W   = 16,
   parameter int          REG_AW   = 8,
   parameter logic [7:0]  PCL_ADDR = 8'h02
) (
   input  logic [WORD_W-1:0] instr,
   output logic              hit,
   output logic              hi_sel,
   output logic              post_inc,
   output logic [REG_AW-1:0] dst,
   output logic              dst_is_pcl
);
   import tblrd_pkg::*;

   generate
      if (WORD_W != 16) begin : g_bad_word
         initial $error("tblrd_decode: WORD_W must be 16");
      end
      if (REG_AW != 8) begin : g_bad_aw
         initial $error("tblrd_decode: REG_AW must be 8");
      end
   endgenerate

   always_comb begin
      hit        = opcode_hit(instr[15:0]);
      hi_sel     = instr[HI_BIT];
      post_inc   = instr[INC_BIT];
      dst        = instr[REG_AW-1:0];
      dst_is_pcl = (instr[REG_AW-1:0] == PCL_ADDR);
   end
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq #(
   parameter int PHASES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic long_run,
   output logic busy,
   output logic wr_phase,
   output logic acc_phase
);
   localparam int MAXPH = 3 * PHASES;
   localparam int PH_W  = $clog2(MAXPH);
   localparam logic [PH_W-1:0] WR_PH   = PH_W'(PHASES - 1);
   localparam logic [PH_W-1:0] ACC_PH  = PH_W'(2 * PHASES - 1);
   localparam logic [PH_W-1:0] LAST2   = PH_W'(2 * PHASES - 1);
   localparam logic [PH_W-1:0] LAST3   = PH_W'(3 * PHASES - 1);

   generate
      if (PHASES < 2) begin : g_bad_ph
         initial $error("tblrd_seq: PHASES must be at least 2");
      end
   endgenerate

   logic [PH_W-1:0] ph_q;
   logic            busy_q;
   logic            long_q;
   logic            at_last;

   assign at_last = long_q ? (ph_q == LAST3) : (ph_q == LAST2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ph_q   <= '0;
         long_q <= 1'b0;
      end else if (!busy_q) begin
         if (go) begin
            busy_q <= 1'b1;
            ph_q   <= '0;
            long_q <= long_run;
         end
      end else if (at_last) begin
         busy_q <= 1'b0;
         ph_q   <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign busy      = busy_q;
   assign wr_phase  = busy_q && (ph_q == WR_PH);
   assign acc_phase = busy_q && (ph_q == ACC_PH);

   // R6: a running execution keeps counting regardless of start
   a_r6_busy_advances: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !at_last |=> busy_q && (ph_q == $past(ph_q) + 1'b1));
   // R5: the execution ends right after its final phase
   a_r5_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && at_last |=> !busy_q);
endmodule

// File: rtl/tblrd_ptr.sv
module tblrd_ptr #(
   parameter int PTR_W  = 16,
   parameter int LANE_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             busy,
   input  logic                             inc,
   input  logic                             ld_en,
   input  logic [$clog2(PTR_W/LANE_W)-1:0]  ld_lane,
   input  logic [LANE_W-1:0]                ld_byte,
   output logic [PTR_W-1:0]                 ptr
);
   localparam int LANES = PTR_W / LANE_W;
   localparam int SEL_W = $clog2(LANES);

   generate
      if (PTR_W % LANE_W != 0 || LANES < 2) begin : g_bad_lanes
         initial $error("tblrd_ptr: PTR_W must be at least two whole lanes");
      end
   endgenerate

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] lane_nxt;
   logic             ld_ok;

   assign ld_ok = ld_en && !busy;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_nxt[g*LANE_W +: LANE_W] =
            (ld_ok && ld_lane == SEL_W'(g)) ? ld_byte : ptr_q[g*LANE_W +: LANE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (inc) ptr_q <= ptr_q + 1'b1;
      else          ptr_q <= lane_nxt;
   end

   assign ptr = ptr_q;

   // R4: post-increment steps by one, modulo 2^PTR_W
   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> ptr_q == $past(ptr_q) + 1'b1);
   // R8: byte loads cannot disturb the pointer during an execution
   a_r8_busy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !inc |=> $stable(ptr_q));
endmodule

// File: rtl/tblrd_latch.sv
module tblrd_latch #(
   parameter int WORD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic [WORD_W-1:0]   din,
   input  logic                hi_sel,
   output logic [WORD_W/2-1:0] sel_byte
);
   localparam int HALF = WORD_W / 2;

   generate
      if (WORD_W % 2 != 0) begin : g_bad_w
         initial $error("tblrd_latch: WORD_W must be even");
      end
   endgenerate

   logic [WORD_W-1:0] lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   lat_q <= '0;
      else if (cap) lat_q <= din;
   end

   assign sel_byte = hi_sel ? lat_q[WORD_W-1:HALF] : lat_q[HALF-1:0];

   // R3: the latch changes only on the fetch phase, and then to memory data
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(lat_q));
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> lat_q == $past(din));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
   parameter int         WORD_W   = 16,
   parameter int         PTR_W    = 16,
   parameter int         REG_AW   = 8,
   parameter int         PHASES   = 4,
   parameter logic [7:0] PCL_ADDR = 8'h02
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [WORD_W-1:0]                instr,
   output logic                             busy,
   output logic                             rf_we,
   output logic [REG_AW-1:0]                rf_addr,
   output logic [WORD_W/2-1:0]              rf_data,
   output logic [PTR_W-1:0]                 pm_addr,
   output logic                             pm_oe_n,
   input  logic [WORD_W-1:0]                pm_data,
   input  logic                             ptr_ld_en,
   input  logic [$clog2(PTR_W/8)-1:0]       ptr_ld_lane,
   input  logic [7:0]                       ptr_ld_byte
);
   logic              d_hit, d_hi, d_inc, d_pcl;
   logic [REG_AW-1:0] d_dst;
   logic              go;
   logic              wr_phase, acc_phase;
   logic              hi_q, inc_q;
   logic [REG_AW-1:0] dst_q;

   tblrd_decode #(.WORD_W(WORD_W), .REG_AW(REG_AW), .PCL_ADDR(PCL_ADDR)) u_dec (
      .instr(instr), .hit(d_hit), .hi_sel(d_hi), .post_inc(d_inc),
      .dst(d_dst), .dst_is_pcl(d_pcl));

   assign go = start && d_hit;

   tblrd_seq #(.PHASES(PHASES)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .long_run(d_pcl),
      .busy(busy), .wr_phase(wr_phase), .acc_phase(acc_phase));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q  <= 1'b0;
         inc_q <= 1'b0;
         dst_q <= '0;
      end else if (go && !busy) begin
         hi_q  <= d_hi;
         inc_q <= d_inc;
         dst_q <= d_dst;
      end
   end

   tblrd_ptr #(.PTR_W(PTR_W), .LANE_W(8)) u_ptr (
      .clk(clk), .rst_n(rst_n), .busy(busy), .inc(acc_phase && inc_q),
      .ld_en(ptr_ld_en), .ld_lane(ptr_ld_lane), .ld_byte(ptr_ld_byte),
      .ptr(pm_addr));

   tblrd_latch #(.WORD_W(WORD_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .cap(acc_phase), .din(pm_data),
      .hi_sel(hi_q), .sel_byte(rf_data));

   assign rf_we   = wr_phase;
   assign rf_addr = dst_q;
   assign pm_oe_n = !acc_phase;

   // R9: memory is read only during an execution
   a_r9_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !pm_oe_n |-> busy);
   // R2: one register write per execution, never two in a row
   a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);
   // R1: an idle unit drives neither write nor read
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> pm_oe_n && !rf_we);
   // R2: the write never coincides with the fetch
   a_r2_write_before_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && !pm_oe_n));
endmodule

// File: tb/tblrd_unit_bench.sv
module tblrd_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [15:0] instr;
   logic        busy, rf_we, pm_oe_n;
   logic [7:0]  rf_addr, rf_data;
   logic [15:0] pm_addr, pm_data;
   logic        ptr_ld_en;
   logic [0:0]  ptr_ld_lane;
   logic [7:0]  ptr_ld_byte;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] m_ptr, m_lat;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] mem_fn(input logic [15:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8] + 8'h21};
   endfunction

   assign pm_data = mem_fn(pm_addr);

   tblrd_unit u_tblrd_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data), .pm_addr(pm_addr),
      .pm_oe_n(pm_oe_n), .pm_data(pm_data), .ptr_ld_en(ptr_ld_en),
      .ptr_ld_lane(ptr_ld_lane), .ptr_ld_byte(ptr_ld_byte));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic load_ptr(input logic [15:0] v);
      @(negedge clk);
      ptr_ld_en = 1'b1; ptr_ld_lane = 1'b0; ptr_ld_byte = v[7:0];
      @(negedge clk);
      ptr_ld_lane = 1'b1; ptr_ld_byte = v[15:8];
      @(negedge clk);
      ptr_ld_en = 1'b0;
      m_ptr = v;
   endtask

   // Run one instruction; optional mid-execution start (R6) or pointer load (R8).
   task automatic exec(input logic [15:0] w, input bit mid_start, input bit mid_load);
      bit          hit;
      int          exp_len, n, wr_cnt, oe_cnt, wr_k, oe_k;
      logic [7:0]  wr_d, wr_a;
      logic [15:0] oe_a, exp_d;
      hit     = (w[15:10] == 6'b101010);
      exp_len = !hit ? 0 : ((w[7:0] == 8'h02) ? 12 : 8);
      exp_d   = w[9] ? {8'h00, m_lat[15:8]} : {8'h00, m_lat[7:0]};
      n = 0; wr_cnt = 0; oe_cnt = 0; wr_k = -1; oe_k = -1;
      wr_d = '0; wr_a = '0; oe_a = '0;
      @(negedge clk);
      start = 1'b1; instr = w;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (!busy) begin
            if (rf_we) wr_cnt++;
            if (!pm_oe_n) oe_cnt++;
            break;
         end
         n++;
         if (rf_we) begin wr_cnt++; wr_k = k; wr_d = rf_data; wr_a = rf_addr; end
         if (!pm_oe_n) begin oe_cnt++; oe_k = k; oe_a = pm_addr; end
         start = (mid_start && k == 2);
         if (mid_start && k == 2) instr = 16'hAB00;
         ptr_ld_en = (mid_load && k == 1);
         ptr_ld_lane = 1'b0; ptr_ld_byte = 8'hEE;
         @(negedge clk);
      end
      start = 1'b0; ptr_ld_en = 1'b0;
      chk(mid_start ? "R6" : "R5", "busy phases", n, exp_len);
      if (!hit) begin
         chk("R1", "writes for foreign opcode", wr_cnt, 0);
         chk("R1", "reads for foreign opcode", oe_cnt, 0);
      end else begin
         chk(mid_start ? "R6" : "R2", "write count", wr_cnt, 1);
         chk("R2", "write phase", wr_k, 3);
         chk("R2", "write address", wr_a, w[7:0]);
         chk("R3", "written byte is old latch", wr_d, exp_d);
         chk("R9", "read count", oe_cnt, 1);
         chk("R9", "read phase", oe_k, 7);
         chk("R3", "read address", oe_a, m_ptr);
         m_lat = mem_fn(m_ptr);
         if (w[8]) m_ptr = m_ptr + 16'd1;
      end
      chk(mid_load ? "R8" : "R4", "pointer after", pm_addr, m_ptr);
   endtask

   // {mid_start, do_load, load value, instruction}
   localparam logic [33:0] VEC [8] = '{
      {1'b0, 1'b1, 16'h1234, 16'hA800},  // t0 i0 f00
      {1'b0, 1'b0, 16'h0000, 16'hAB10},  // t1 i1
      {1'b0, 1'b0, 16'h0000, 16'hA902},  // PCL destination, long
      {1'b0, 1'b0, 16'h0000, 16'hAA20},  // t1 i0
      {1'b0, 1'b1, 16'hFFFF, 16'hAB55},  // wrap
      {1'b1, 1'b0, 16'h0000, 16'hA977},  // start while busy
      {1'b0, 1'b0, 16'h0000, 16'h1C12},  // foreign opcode
      {1'b0, 1'b0, 16'h0000, 16'hABFF}   // t1 i1 f FF
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; instr = '0;
      ptr_ld_en = 1'b0; ptr_ld_lane = '0; ptr_ld_byte = '0;
      m_ptr = '0; m_lat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state
      chk("R7", "busy after reset", busy, 0);
      chk("R7", "rf_we after reset", rf_we, 0);
      chk("R7", "pm_oe_n after reset", pm_oe_n, 1);
      chk("R7", "pointer after reset", pm_addr, 0);
      // R7: zero latch seen through first low-byte read
      exec(16'hA840, 1'b0, 1'b0);

      foreach (VEC[j]) begin
         if (VEC[j][32]) load_ptr(VEC[j][31:16]);
         exec(VEC[j][15:0], VEC[j][33], 1'b0);
      end

      // R8: load during execution is ignored; idle loads take each lane
      exec(16'hA830, 1'b0, 1'b1);
      load_ptr(16'h4C3B);
      chk("R8", "lane load value", pm_addr, 16'h4C3B);
      @(negedge clk);
      ptr_ld_en = 1'b1; ptr_ld_lane = 1'b1; ptr_ld_byte = 8'h90;
      @(negedge clk);
      ptr_ld_en = 1'b0;
      chk("R8", "high lane only", pm_addr, 16'h903B);
      m_ptr = 16'h903B;
      exec(16'hAB00, 1'b0, 1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule